// File: doc/BRIEF.md
# Bus Ownership and Backoff Controller

This block decides, clock by clock, whether a bus master drives the shared bus or lets go of it. It accepts an internal request for a bus cycle and starts that cycle with a one-clock strobe. The cycle then stays in progress until the active-low ready input is sampled low. While the cycle runs, the block watches two external demands. A hold request is honoured gracefully: any cycle in flight completes, then the bus outputs float and an acknowledge goes out to the other masters. An active-low backoff request is honoured at once: the cycle in flight is abandoned, the bus floats without any acknowledge, and the abandoned cycle is replayed from its start when backoff lifts.

When the master has work but the bus is floated, the block raises a bus-request flag for an external arbiter. All outputs are registered. Reset is synchronous and active high.

Top module: `bus_own_ctrl`

## Requirements
- R1: After reset all outputs are 0: the bus is driven (float_o=0), with no acknowledge, request, start or abort.
- R2: With the bus driven, no cycle in progress, hold_i=0 and boff_n_i=1, an edge that samples cyc_req_i=1 makes start_o equal 1 for exactly the following clock, and a cycle is then in progress.
- R3: A cycle in progress completes only at an edge that samples rdy_n_i=0. Each edge that samples rdy_n_i=1 adds a wait state, and a pending hold is not acknowledged before completion.
- R4: An edge that samples hold_i=1 and boff_n_i=1 with no cycle in progress or aborted sets float_o=1 and hlda_o=1 after that edge. This includes the edge that completes a cycle, and hold wins over a waiting cyc_req_i.
- R5: While held, the first edge that samples hold_i=0 (with boff_n_i=1) clears hlda_o and float_o after that edge. A waiting request then starts at the next edge.
- R6: An edge that samples boff_n_i=0 sets float_o=1 and hlda_o=0 after that edge, whatever the state. If a cycle was in progress, abort_o is 1 for that one following clock only.
- R7: A cycle aborted by backoff is started again at the first edge that samples boff_n_i=1, with a fresh start_o pulse, and must then complete with ready.
- R8: Backoff takes priority over hold. With both active, hlda_o stays 0. On release of backoff, an aborted cycle is replayed and completed first, and only then is hold acknowledged.
- R9: breq_o is 1 after an edge exactly when the bus is floated after that edge and a cycle is waiting: cyc_req_i sampled 1 or an aborted cycle pending. It is 0 whenever the bus is driven.
- R10: cyc_req_i is ignored while a cycle is in progress: no second start_o occurs before the current cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_req_i | input | 1 | A bus cycle is waiting to be started (level) |
| rdy_n_i | input | 1 | Active-low ready; the cycle ends when sampled low |
| hold_i | input | 1 | Request to hand over the bus after the current cycle |
| boff_n_i | input | 1 | Active-low immediate backoff |
| breq_o | output | 1 | Master needs the bus while floated |
| hlda_o | output | 1 | Bus handed over in response to hold |
| float_o | output | 1 | Bus drivers must be tri-stated |
| start_o | output | 1 | One-clock strobe marking the start of a bus cycle |
| abort_o | output | 1 | One-clock strobe marking a cycle killed by backoff |

## Verification
The assertions assume that the requester keeps cyc_req_i high until it sees start_o and drops it before the cycle it started completes. They also assume that all four inputs change only between clock edges. The stimulus drives every input on the falling edge and withdraws each request in the clock after its start strobe. Hold and backoff are applied in every state: idle, mid-cycle, held and backed off. They are applied singly and together, so the priority and replay paths are reached without breaking those input assumptions.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HELD = 2'd2,
    ST_BOFF = 2'd3
  } own_st_e;

  typedef struct packed {
    logic flt;
    logic hlda;
    logic breq;
    logic start;
    logic abort;
  } own_out_t;

endpackage

// File: rtl/bus_own_nsl.sv
module bus_own_nsl
  import bus_own_pkg::*;
(
  input  own_st_e st,
  input  logic    pend,
  input  logic    req,
  input  logic    rdy_n,
  input  logic    hold,
  input  logic    boff_n,
  output own_st_e st_nx,
  output logic    pend_nx,
  output logic    start_nx,
  output logic    abort_nx
);

  always_comb begin
    st_nx    = st;
    pend_nx  = pend;
    start_nx = 1'b0;
    abort_nx = 1'b0;
    if (!boff_n) begin
      st_nx = ST_BOFF;
      if (st == ST_BUSY) begin
        pend_nx  = 1'b1;
        abort_nx = 1'b1;
      end
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (hold) begin
            st_nx = ST_HELD;
          end else if (req) begin
            st_nx    = ST_BUSY;
            start_nx = 1'b1;
          end
        end
        ST_BUSY: begin
          if (!rdy_n) st_nx = hold ? ST_HELD : ST_IDLE;
        end
        ST_HELD: begin
          if (!hold) st_nx = ST_IDLE;
        end
        ST_BOFF: begin
          if (pend) begin
            st_nx    = ST_BUSY;
            start_nx = 1'b1;
            pend_nx  = 1'b0;
          end else if (hold) begin
            st_nx = ST_HELD;
          end else begin
            st_nx = ST_IDLE;
          end
        end
        default: st_nx = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_own_regs.sv
module bus_own_regs
  import bus_own_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  own_st_e  st_nx,
  input  logic     pend_nx,
  input  logic     start_nx,
  input  logic     abort_nx,
  input  logic     req,
  output own_st_e  st,
  output logic     pend,
  output own_out_t outs
);

  logic flt_nx;
  assign flt_nx = (st_nx == ST_HELD) || (st_nx == ST_BOFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
      outs <= '0;
    end else begin
      st         <= st_nx;
      pend       <= pend_nx;
      outs.flt   <= flt_nx;
      outs.hlda  <= (st_nx == ST_HELD);
      outs.breq  <= flt_nx && (req || pend_nx);
      outs.start <= start_nx;
      outs.abort <= abort_nx;
    end
  end

  // Replay flag only lives while backed off
  AST_PEND_ONLY_BOFF: assert property (@(posedge clk) disable iff (rst)
    pend |-> (st == ST_BOFF)) else $error("pending replay outside backoff"); // R7

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_req_i,
  input  logic rdy_n_i,
  input  logic hold_i,
  input  logic boff_n_i,
  output logic breq_o,
  output logic hlda_o,
  output logic float_o,
  output logic start_o,
  output logic abort_o
);

  own_st_e  st, st_nx;
  logic     pend, pend_nx, start_nx, abort_nx;
  own_out_t outs;

  bus_own_nsl u_nsl (
    .st       (st),
    .pend     (pend),
    .req      (cyc_req_i),
    .rdy_n    (rdy_n_i),
    .hold     (hold_i),
    .boff_n   (boff_n_i),
    .st_nx    (st_nx),
    .pend_nx  (pend_nx),
    .start_nx (start_nx),
    .abort_nx (abort_nx)
  );

  bus_own_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .st_nx    (st_nx),
    .pend_nx  (pend_nx),
    .start_nx (start_nx),
    .abort_nx (abort_nx),
    .req      (cyc_req_i),
    .st       (st),
    .pend     (pend),
    .outs     (outs)
  );

  assign float_o = outs.flt;
  assign hlda_o  = outs.hlda;
  assign breq_o  = outs.breq;
  assign start_o = outs.start;
  assign abort_o = outs.abort;

  AST_HLDA_FLOATS: assert property (@(posedge clk) disable iff (rst)
    hlda_o |-> float_o) else $error("acknowledge without float"); // R4

  AST_BOFF_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !boff_n_i |=> (float_o && !hlda_o)) else $error("backoff not honoured"); // R6

  AST_ABORT_ONE: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o) else $error("abort longer than one clock"); // R6

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (hlda_o && !hold_i && boff_n_i) |=> (!hlda_o && !float_o)) else $error("hold release late"); // R5

  AST_START_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (!float_o && !breq_o)) else $error("start while floated"); // R9

  AST_NO_DOUBLE_START: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o) else $error("back-to-back start"); // R10

  AST_NO_ACK_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY && rdy_n_i && boff_n_i) |=> !hlda_o) else $error("hold acknowledged mid-cycle"); // R3

endmodule

// File: tb/test_bus_own_ctrl.sv
module test_bus_own_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_req_i = 1'b0;
  logic rdy_n_i = 1'b1;
  logic hold_i = 1'b0;
  logic boff_n_i = 1'b1;
  logic breq_o, hlda_o, float_o, start_o, abort_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_own_ctrl i_bus_own_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cyc_req_i (cyc_req_i),
    .rdy_n_i   (rdy_n_i),
    .hold_i    (hold_i),
    .boff_n_i  (boff_n_i),
    .breq_o    (breq_o),
    .hlda_o    (hlda_o),
    .float_o   (float_o),
    .start_o   (start_o),
    .abort_o   (abort_o)
  );

  // Driver: apply inputs on the falling edge, queue the expected outputs
  // {float, hlda, breq, start, abort} seen after the next rising edge.
  task automatic step(input logic rq, input logic rn, input logic hd,
                      input logic bn, input logic [4:0] exp, input string tag);
    @(negedge clk);
    cyc_req_i = rq;
    rdy_n_i   = rn;
    hold_i    = hd;
    boff_n_i  = bn;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: sample a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {float_o, hlda_o, breq_o, start_o, abort_o};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s: {flt,hlda,breq,start,abort} actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(0,1,0,1, 5'b00000, "R1 in reset");
    step(0,1,0,1, 5'b00000, "R1 in reset");
    @(negedge clk); rst = 1'b0;
    step(0,1,0,1, 5'b00000, "R1 idle after reset");
    // R2 start, R3 wait states and hold deferred to completion
    step(1,1,0,1, 5'b00010, "R2 start strobe");
    step(0,1,0,1, 5'b00000, "R3 wait state");
    step(0,1,1,1, 5'b00000, "R3 hold waits for cycle");
    step(0,0,1,1, 5'b11000, "R3 completion then hold ack");
    // R9 request while held, R5 release
    step(1,1,1,1, 5'b11100, "R9 breq while held");
    step(1,1,0,1, 5'b00000, "R5 release hold");
    step(1,1,0,1, 5'b00010, "R5 waiting request starts");
    step(0,0,0,1, 5'b00000, "R3 zero-wait completion");
    // R4 hold from idle
    step(0,1,1,1, 5'b11000, "R4 hold from idle");
    step(0,1,0,1, 5'b00000, "R5 release from idle hold");
    // R6 backoff mid-cycle, R7 replay
    step(1,1,0,1, 5'b00010, "R2 start before backoff");
    step(0,1,0,0, 5'b10101, "R6 abort and float");
    step(0,1,0,0, 5'b10100, "R6 abort single pulse, R9 pending");
    step(0,1,0,1, 5'b00010, "R7 replay start");
    step(0,1,0,1, 5'b00000, "R7 replay wait");
    step(0,0,0,1, 5'b00000, "R7 replay completes");
    // R8 both active from idle
    step(0,1,1,0, 5'b10000, "R8 backoff beats hold");
    step(0,1,1,0, 5'b10000, "R8 still no ack");
    step(0,1,1,1, 5'b11000, "R8 ack after backoff release");
    step(0,1,1,0, 5'b10000, "R6 backoff while held drops ack");
    step(0,1,0,1, 5'b00000, "R6 release to idle");
    // R8 both active mid-cycle
    step(1,1,0,1, 5'b00010, "R2 start");
    step(0,1,1,0, 5'b10101, "R8 abort with hold");
    step(0,1,1,1, 5'b00010, "R8 replay before ack");
    step(0,1,1,1, 5'b00000, "R8 no ack mid replay");
    step(0,0,1,1, 5'b11000, "R8 ack after replay");
    step(0,1,0,1, 5'b00000, "R5 release");
    // R10 request held high during a cycle
    step(1,1,0,1, 5'b00010, "R10 start");
    step(1,1,0,1, 5'b00000, "R10 request ignored mid-cycle");
    step(0,0,0,1, 5'b00000, "R10 completion");
    // R4 hold wins over waiting request, R9 breq tracking
    step(1,1,1,1, 5'b11100, "R4 hold over request, R9 breq");
    step(1,1,1,0, 5'b10100, "R9 breq in backoff");
    step(0,1,1,0, 5'b10000, "R9 breq drops with request");
    step(0,1,0,1, 5'b00000, "R9 driven bus no breq");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule